// File: doc/BRIEF.md
# Trap Entry Dispatcher

This block is the entry logic for interrupts and synchronous exceptions in a small processor core. Each cycle it looks at the pending interrupt level, the raw pending and enable masks, the processor status word it owns and the program counter of the instruction being retired. It then decides whether the core must leave its normal flow. When it does, it saves the return context into banked registers, rewrites the status word and produces a new fetch address taken from a fixed vector map.

Interrupts above level 1 go straight to a vector for each level. They keep their own return-PC and return-status registers. A level-1 interrupt is turned into a general exception instead. It becomes a user or kernel exception when the core is not already handling one. If the exception-mode bit is already set, it becomes a double exception. Synchronous exception requests from the pipeline are sent to their own vectors. A request whose vector is empty is reported as a bad exception, and the fetch address stays where it is. All state changes at one clock edge, and the decision is made combinationally in the cycle before.

Top module: `trap_entry`

## Requirements
- R1: Reset is synchronous and active low. After reset the fetch address is 0x5FFF8000. The status word is 0x1F, or 0x10 when interrupt support is configured off. Bit 0 of the literal-base register is cleared while its other bits keep their value. The taken and bad-exception flags are 0.
- R2: An interrupt is taken only when all three conditions hold. The pending level is above the status interrupt-level field (bits 3:0). It is no higher than NLEVEL (6). The level's mask ANDed with the pending and enable masks is nonzero. Otherwise no register changes.
- R3: On a taken interrupt of level L of 2 or more, the retired PC goes to return-PC slot L and the old status word goes to return-status slot L. The status field 3:0 becomes L and bit 4 (exception mode) is set, with other status bits kept. The fetch address becomes 0x5FFF857C + (L-2)*0x20.
- R4: On a taken level-1 interrupt while status bit 4 is clear, the retired PC goes to return-PC slot 1 and the cause register becomes 4. Status bit 4 is set. The fetch address becomes 0x5FFF863C if status bit 5 (user mode) is set, otherwise 0x5FFF861C.
- R5: On a taken level-1 interrupt while status bit 4 is set, the cause register becomes 4 and the fetch address becomes 0x5FFF865C. The retired PC goes to the double-exception PC register when that register is configured, otherwise to return-PC slot 1.
- R6: A synchronous request with code c redirects the fetch address to its vector and changes no saved register. The vectors are: 0 kernel 0x5FFF861C, 1 user 0x5FFF863C, 2 double 0x5FFF865C, 3 to 8 window spill/fill at 0x5FFF8400 + (c-3)*0x40.
- R7: A synchronous request with a code of 9 to 15 has an empty vector. It raises the bad-exception flag for one cycle and leaves the fetch address and the taken flag unchanged.
- R8: When a synchronous request and a qualifying interrupt fall in the same cycle, the request is served. The interrupt leaves no trace in the saved registers, the cause register or the status word.
- R9: The taken flag is high for exactly the one cycle in which a new fetch address first shows, and never together with the bad-exception flag.
- R10: A status write or a literal-base write from the core takes effect at the next edge. If an interrupt is taken in the same cycle, the interrupt's status update wins over the status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_level_i | input | 4 | Highest pending interrupt level |
| irq_set_i | input | NIRQ | Raw pending interrupt lines |
| irq_en_i | input | NIRQ | Interrupt enable mask |
| exc_req_i | input | 1 | Synchronous exception request |
| exc_code_i | input | 4 | Code of the requested exception |
| core_pc_i | input | 32 | PC of the instruction to return to |
| ps_wr_en_i | input | 1 | Core write of the status word |
| ps_wr_data_i | input | 8 | Status word write value |
| lbase_wr_en_i | input | 1 | Core write of the literal-base register |
| lbase_wr_data_i | input | 32 | Literal-base write value |
| fetch_pc_o | output | 32 | Current fetch target |
| taken_o | output | 1 | One-cycle pulse on redirection |
| bad_exc_o | output | 1 | One-cycle pulse on an empty-vector request |
| ps_o | output | 8 | Status word |
| lbase_o | output | 32 | Literal-base register |
| epc_o | output | NLEVEL*32 | Return-PC slots 1..NLEVEL, slot L at bits (L-1)*32 |
| eps_o | output | (NLEVEL-1)*8 | Return-status slots 2..NLEVEL, slot L at bits (L-2)*8 |
| depc_o | output | 32 | Double-exception PC |
| exccause_o | output | 6 | Exception cause register |

## Verification
A synchronous exception request and a qualifying interrupt can arrive in the same cycle. So can a core status write and an interrupt entry. Random stimulus raises the request in about one cycle in five and the status write in about one in six, while interrupt lines and levels keep changing. Directed cycles also stack each pair on purpose. The bench model serves the request first and lets the interrupt's status update win. It then checks that the losing event left the saved registers, the cause register and the status word exactly as they were.

// File: rtl/trap_pkg.sv
// Shared constants, status-word field positions, exception codes and
// vector computation for the trap entry dispatcher.
package trap_pkg;
    localparam int XLEN   = 32;
    localparam int PSW    = 8;
    localparam int LVW    = 4;
    localparam int CODEW  = 4;
    localparam int CAUSEW = 6;

    // status word fields
    localparam int PS_EXCM = 4;
    localparam int PS_UM   = 5;

    localparam logic [CAUSEW-1:0] CAUSE_L1_IRQ = 6'd4;
    localparam logic [XLEN-1:0]   VEC_RESET    = 32'h5FFF_8000;
    localparam logic [XLEN-1:0]   VEC_KERNEL   = 32'h5FFF_861C;
    localparam logic [XLEN-1:0]   VEC_USER     = 32'h5FFF_863C;
    localparam logic [XLEN-1:0]   VEC_DOUBLE   = 32'h5FFF_865C;
    localparam logic [XLEN-1:0]   VEC_LVL2     = 32'h5FFF_857C;
    localparam logic [XLEN-1:0]   VEC_WINDOW   = 32'h5FFF_8400;

    typedef enum logic [CODEW-1:0] {
        EXC_KERNEL = 4'd0,
        EXC_USER   = 4'd1,
        EXC_DOUBLE = 4'd2,
        EXC_WSPL4  = 4'd3,
        EXC_WFIL4  = 4'd4,
        EXC_WSPL8  = 4'd5,
        EXC_WFIL8  = 4'd6,
        EXC_WSPL12 = 4'd7,
        EXC_WFIL12 = 4'd8
    } exc_code_e;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_SYNC,
        ACT_BAD,
        ACT_HIGH,
        ACT_LOW
    } act_e;

    // Vector of a synchronous exception code; zero means no vector.
    function automatic logic [XLEN-1:0] sync_vector(input logic [CODEW-1:0] code);
        logic [XLEN-1:0] v;
        case (code)
            EXC_KERNEL: v = VEC_KERNEL;
            EXC_USER:   v = VEC_USER;
            EXC_DOUBLE: v = VEC_DOUBLE;
            EXC_WSPL4, EXC_WFIL4, EXC_WSPL8,
            EXC_WFIL8, EXC_WSPL12, EXC_WFIL12:
                v = VEC_WINDOW + ((32'(code) - 32'd3) << 6);
            default:    v = '0;
        endcase
        return v;
    endfunction

    // Vector of a high-priority interrupt level (2 and up).
    function automatic logic [XLEN-1:0] level_vector(input logic [LVW-1:0] lvl);
        logic [XLEN-1:0] v;
        if (lvl >= 4'd2) v = VEC_LVL2 + ((32'(lvl) - 32'd2) << 5);
        else             v = '0;
        return v;
    endfunction
endpackage

// File: rtl/trap_irq_qualify.sv
// Decides whether the pending interrupt level may be taken.
// Assumes irq_set/irq_en are already synchronised to clk.
module trap_irq_qualify
    import trap_pkg::*;
#(
    parameter int NIRQ   = 13,
    parameter int NLEVEL = 6,
    parameter logic [NLEVEL*NIRQ-1:0] LEVEL_MASK = (NLEVEL*NIRQ)'(1) << (3*NIRQ)
) (
    input  logic [LVW-1:0]  irq_level,
    input  logic [LVW-1:0]  cur_level,
    input  logic [NIRQ-1:0] irq_set,
    input  logic [NIRQ-1:0] irq_en,
    output logic            take
);
    logic [NLEVEL:1] lvl_hit;
    logic            sel_hit;

    // one hit flag per level: mask AND pending AND enabled
    for (genvar l = 1; l <= NLEVEL; l++) begin : g_hit
        assign lvl_hit[l] = |(LEVEL_MASK[(l-1)*NIRQ +: NIRQ] & irq_set & irq_en);
    end

    // select the pending level's hit and compare against current level
    always_comb begin
        sel_hit = 1'b0;
        for (int l = 1; l <= NLEVEL; l++) begin
            if (irq_level == LVW'(l)) sel_hit = lvl_hit[l];
        end
        take = sel_hit && (irq_level > cur_level);
    end
endmodule

// File: rtl/trap_decide.sv
// Chooses the trap action for this cycle, its target and the new status.
// Assumes irq_take already includes all qualification conditions.
module trap_decide
    import trap_pkg::*;
(
    input  logic             exc_req,
    input  logic [CODEW-1:0] exc_code,
    input  logic             irq_take,
    input  logic [LVW-1:0]   irq_level,
    input  logic [PSW-1:0]   ps,
    output act_e             act,
    output logic [XLEN-1:0]  target,
    output logic [PSW-1:0]   ps_trap,
    output logic             to_double
);
    // priority: synchronous request, then high level, then level 1
    always_comb begin
        act       = ACT_IDLE;
        target    = '0;
        ps_trap   = ps;
        to_double = 1'b0;
        if (exc_req) begin
            target = sync_vector(exc_code);
            act    = (target != '0) ? ACT_SYNC : ACT_BAD;
        end else if (irq_take) begin
            ps_trap[PS_EXCM] = 1'b1;
            if (irq_level > 4'd1) begin
                act            = ACT_HIGH;
                target         = level_vector(irq_level);
                ps_trap[3:0]   = irq_level;
            end else begin
                act = ACT_LOW;
                if (ps[PS_EXCM]) begin
                    to_double = 1'b1;
                    target    = VEC_DOUBLE;
                end else if (ps[PS_UM]) begin
                    target = VEC_USER;
                end else begin
                    target = VEC_KERNEL;
                end
            end
        end
    end
endmodule

// File: rtl/trap_regs.sv
// Holds fetch target, status word, literal base, banked return registers
// and cause register; applies one trap action per clock edge.
module trap_regs
    import trap_pkg::*;
#(
    parameter int NLEVEL   = 6,
    parameter bit HAS_DEPC = 1'b1,
    parameter bit HAS_INTR = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  act_e                      act,
    input  logic [XLEN-1:0]           target,
    input  logic [PSW-1:0]            ps_trap,
    input  logic                      to_double,
    input  logic [LVW-1:0]            irq_level,
    input  logic [XLEN-1:0]           core_pc,
    input  logic                      ps_wr_en,
    input  logic [PSW-1:0]            ps_wr_data,
    input  logic                      lbase_wr_en,
    input  logic [XLEN-1:0]           lbase_wr_data,
    output logic [XLEN-1:0]           fetch_pc,
    output logic                      taken,
    output logic                      bad_exc,
    output logic [PSW-1:0]            ps,
    output logic [XLEN-1:0]           lbase,
    output logic [NLEVEL*XLEN-1:0]    epc,
    output logic [(NLEVEL-1)*PSW-1:0] eps,
    output logic [XLEN-1:0]           depc,
    output logic [CAUSEW-1:0]         exccause
);
    localparam logic [PSW-1:0] PS_RESET = HAS_INTR ? 8'h1F : 8'h10;

    logic redirect;
    logic irq_entry;
    logic l1_to_epc1;

    assign redirect   = (act == ACT_SYNC) || (act == ACT_HIGH) || (act == ACT_LOW);
    assign irq_entry  = (act == ACT_HIGH) || (act == ACT_LOW);
    assign l1_to_epc1 = (act == ACT_LOW) && !(to_double && HAS_DEPC);

    // fetch target and one-cycle outcome flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_pc <= VEC_RESET;
            taken    <= 1'b0;
            bad_exc  <= 1'b0;
        end else begin
            taken   <= redirect;
            bad_exc <= (act == ACT_BAD);
            if (redirect) fetch_pc <= target;
        end
    end

    // status word: interrupt entry wins over core write
    always_ff @(posedge clk) begin
        if (!rst_n)         ps <= PS_RESET;
        else if (irq_entry) ps <= ps_trap;
        else if (ps_wr_en)  ps <= ps_wr_data;
    end

    // literal base: reset clears only bit 0
    always_ff @(posedge clk) begin
        if (!rst_n)           lbase <= {lbase[XLEN-1:1], 1'b0};
        else if (lbase_wr_en) lbase <= lbase_wr_data;
    end

    // cause register loaded by level-1 entry
    always_ff @(posedge clk) begin
        if (!rst_n)              exccause <= '0;
        else if (act == ACT_LOW) exccause <= CAUSE_L1_IRQ;
    end

    // banked return-PC slots, slot 1 shared by level-1 entries
    for (genvar l = 1; l <= NLEVEL; l++) begin : g_epc
        logic save;
        if (l == 1) begin : g_one
            assign save = l1_to_epc1;
        end else begin : g_hi
            assign save = (act == ACT_HIGH) && (irq_level == LVW'(l));
        end
        // capture return PC for this slot
        always_ff @(posedge clk) begin
            if (!rst_n)    epc[(l-1)*XLEN +: XLEN] <= '0;
            else if (save) epc[(l-1)*XLEN +: XLEN] <= core_pc;
        end
    end

    // banked return-status slots for levels 2 and up
    for (genvar l = 2; l <= NLEVEL; l++) begin : g_eps
        // capture pre-entry status for this level
        always_ff @(posedge clk) begin
            if (!rst_n)
                eps[(l-2)*PSW +: PSW] <= '0;
            else if ((act == ACT_HIGH) && (irq_level == LVW'(l)))
                eps[(l-2)*PSW +: PSW] <= ps;
        end
    end

    if (HAS_DEPC) begin : g_depc
        // capture return PC of a double exception
        always_ff @(posedge clk) begin
            if (!rst_n)                            depc <= '0;
            else if ((act == ACT_LOW) && to_double) depc <= core_pc;
        end
    end else begin : g_no_depc
        assign depc = '0;
    end
endmodule

// File: rtl/trap_entry.sv
// Top of the trap entry dispatcher: qualification, decision, state.
// Assumes all inputs are synchronous to clk; one action per cycle.
module trap_entry
    import trap_pkg::*;
#(
    parameter int NIRQ     = 13,
    parameter int NLEVEL   = 6,
    parameter bit HAS_DEPC = 1'b1,
    parameter bit HAS_INTR = 1'b1,
    parameter logic [NLEVEL*NIRQ-1:0] LEVEL_MASK = (NLEVEL*NIRQ)'(1) << (3*NIRQ)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [3:0]                irq_level_i,
    input  logic [NIRQ-1:0]           irq_set_i,
    input  logic [NIRQ-1:0]           irq_en_i,
    input  logic                      exc_req_i,
    input  logic [3:0]                exc_code_i,
    input  logic [31:0]               core_pc_i,
    input  logic                      ps_wr_en_i,
    input  logic [7:0]                ps_wr_data_i,
    input  logic                      lbase_wr_en_i,
    input  logic [31:0]               lbase_wr_data_i,
    output logic [31:0]               fetch_pc_o,
    output logic                      taken_o,
    output logic                      bad_exc_o,
    output logic [7:0]                ps_o,
    output logic [31:0]               lbase_o,
    output logic [NLEVEL*32-1:0]      epc_o,
    output logic [(NLEVEL-1)*8-1:0]   eps_o,
    output logic [31:0]               depc_o,
    output logic [5:0]                exccause_o
);
    logic            irq_take;
    act_e            act;
    logic [XLEN-1:0] target;
    logic [PSW-1:0]  ps_trap;
    logic            to_double;

    trap_irq_qualify #(
        .NIRQ(NIRQ), .NLEVEL(NLEVEL), .LEVEL_MASK(LEVEL_MASK)
    ) u_qualify (
        .irq_level (irq_level_i),
        .cur_level (ps_o[3:0]),
        .irq_set   (irq_set_i),
        .irq_en    (irq_en_i),
        .take      (irq_take)
    );

    trap_decide u_decide (
        .exc_req   (exc_req_i),
        .exc_code  (exc_code_i),
        .irq_take  (irq_take),
        .irq_level (irq_level_i),
        .ps        (ps_o),
        .act       (act),
        .target    (target),
        .ps_trap   (ps_trap),
        .to_double (to_double)
    );

    trap_regs #(
        .NLEVEL(NLEVEL), .HAS_DEPC(HAS_DEPC), .HAS_INTR(HAS_INTR)
    ) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .act           (act),
        .target        (target),
        .ps_trap       (ps_trap),
        .to_double     (to_double),
        .irq_level     (irq_level_i),
        .core_pc       (core_pc_i),
        .ps_wr_en      (ps_wr_en_i),
        .ps_wr_data    (ps_wr_data_i),
        .lbase_wr_en   (lbase_wr_en_i),
        .lbase_wr_data (lbase_wr_data_i),
        .fetch_pc      (fetch_pc_o),
        .taken         (taken_o),
        .bad_exc       (bad_exc_o),
        .ps            (ps_o),
        .lbase         (lbase_o),
        .epc           (epc_o),
        .eps           (eps_o),
        .depc          (depc_o),
        .exccause      (exccause_o)
    );
endmodule

// File: rtl/trap_entry_chk.sv
// Temporal checks on the trap entry dispatcher ports, bound to the top.
module trap_entry_chk #(
    parameter int NLEVEL = 6
) (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  irq_level_i,
    input logic        exc_req_i,
    input logic        ps_wr_en_i,
    input logic [31:0] fetch_pc_o,
    input logic        taken_o,
    input logic        bad_exc_o,
    input logic [7:0]  ps_o
);
    // R9
    taken_bad_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(taken_o && bad_exc_o));

    // R7
    bad_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_exc_o |-> $past(exc_req_i));

    // R7
    bad_keeps_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_exc_o |-> $stable(fetch_pc_o));

    // R2
    taken_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> ($past(exc_req_i) ||
                     (($past(irq_level_i) > $past(ps_o[3:0])) &&
                      (32'($past(irq_level_i)) <= NLEVEL))));

    // R3
    irq_excm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (taken_o && !$past(exc_req_i)) |-> ps_o[4]);

    // R6
    sync_keeps_ps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (taken_o && $past(exc_req_i) && !$past(ps_wr_en_i)) |-> $stable(ps_o));
endmodule

bind trap_entry trap_entry_chk #(.NLEVEL(NLEVEL)) u_trap_entry_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_level_i (irq_level_i),
    .exc_req_i   (exc_req_i),
    .ps_wr_en_i  (ps_wr_en_i),
    .fetch_pc_o  (fetch_pc_o),
    .taken_o     (taken_o),
    .bad_exc_o   (bad_exc_o),
    .ps_o        (ps_o)
);

// File: tb/test_trap_entry.sv
// Random plus directed bench for trap_entry against a bench-side model.
module test_trap_entry;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 6;
    localparam int NI = 13;

    // every level gets two lines, plus line 0 at level 4
    function automatic logic [NL*NI-1:0] bench_mask();
        logic [NL*NI-1:0] m = '0;
        for (int l = 1; l <= NL; l++) begin
            m[(l-1)*NI + 2*l - 1] = 1'b1;
            m[(l-1)*NI + 2*l]     = 1'b1;
        end
        m[3*NI] = 1'b1;
        return m;
    endfunction
    localparam logic [NL*NI-1:0] TB_MASK = bench_mask();

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [3:0]         irq_level = '0;
    logic [NI-1:0]      irq_set = '0, irq_en = '0;
    logic               exc_req = 1'b0;
    logic [3:0]         exc_code = '0;
    logic [31:0]        core_pc = '0;
    logic               ps_wr_en = 1'b0;
    logic [7:0]         ps_wr_data = '0;
    logic               lbase_wr_en = 1'b0;
    logic [31:0]        lbase_wr_data = '0;
    logic [31:0]        fetch_pc, lbase, depc;
    logic               taken, bad_exc;
    logic [7:0]         ps;
    logic [NL*32-1:0]   epc;
    logic [(NL-1)*8-1:0] eps;
    logic [5:0]         exccause;

    trap_entry #(.NIRQ(NI), .NLEVEL(NL), .LEVEL_MASK(TB_MASK)) i_trap_entry (
        .clk(clk), .rst_n(rst_n), .irq_level_i(irq_level), .irq_set_i(irq_set),
        .irq_en_i(irq_en), .exc_req_i(exc_req), .exc_code_i(exc_code),
        .core_pc_i(core_pc), .ps_wr_en_i(ps_wr_en), .ps_wr_data_i(ps_wr_data),
        .lbase_wr_en_i(lbase_wr_en), .lbase_wr_data_i(lbase_wr_data),
        .fetch_pc_o(fetch_pc), .taken_o(taken), .bad_exc_o(bad_exc), .ps_o(ps),
        .lbase_o(lbase), .epc_o(epc), .eps_o(eps), .depc_o(depc),
        .exccause_o(exccause)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_err = 0;

    logic [31:0] m_fetch, m_lbase, m_depc;
    logic [31:0] m_epc [1:NL];
    logic [7:0]  m_eps [2:NL];
    logic [7:0]  m_ps;
    logic [5:0]  m_cause;
    logic        m_taken, m_bad;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_sync_vec(input logic [3:0] c);
        case (c)
            4'd0: return 32'h5FFF_861C;
            4'd1: return 32'h5FFF_863C;
            4'd2: return 32'h5FFF_865C;
            4'd3: return 32'h5FFF_8400;
            4'd4: return 32'h5FFF_8440;
            4'd5: return 32'h5FFF_8480;
            4'd6: return 32'h5FFF_84C0;
            4'd7: return 32'h5FFF_8500;
            4'd8: return 32'h5FFF_8540;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] exp_lvl_vec(input logic [3:0] l);
        case (l)
            4'd2: return 32'h5FFF_857C;
            4'd3: return 32'h5FFF_859C;
            4'd4: return 32'h5FFF_85BC;
            4'd5: return 32'h5FFF_85DC;
            default: return 32'h5FFF_85FC;
        endcase
    endfunction

    task automatic compare_all(input string tag);
        check("R9", "taken", 32'(taken), 32'(m_taken));
        check(tag, "fetch_pc", fetch_pc, m_fetch);
        check("R7", "bad_exc", 32'(bad_exc), 32'(m_bad));
        check(tag, "ps", 32'(ps), 32'(m_ps));
        check(tag, "exccause", 32'(exccause), 32'(m_cause));
        check(tag, "depc", depc, m_depc);
        check("R10", "lbase", lbase, m_lbase);
        for (int l = 1; l <= NL; l++) check(tag, "epc", epc[(l-1)*32 +: 32], m_epc[l]);
        for (int l = 2; l <= NL; l++) check(tag, "eps", 32'(eps[(l-2)*8 +: 8]), 32'(m_eps[l]));
    endtask

    // one cycle: drive at negedge, update model, compare after the edge
    task automatic step(input logic [3:0] lvl, input logic [NI-1:0] st, input logic [NI-1:0] en,
                        input logic xr, input logic [3:0] xc, input logic [31:0] pc,
                        input logic pw, input logic [7:0] pd,
                        input logic lw, input logic [31:0] ld);
        logic  q;
        logic  irq_chg;
        string tag;
        @(negedge clk);
        irq_level = lvl; irq_set = st; irq_en = en; exc_req = xr; exc_code = xc;
        core_pc = pc; ps_wr_en = pw; ps_wr_data = pd; lbase_wr_en = lw; lbase_wr_data = ld;
        q = 1'b0;
        for (int l = 1; l <= NL; l++)
            if (int'(lvl) == l && lvl > m_ps[3:0] && |(TB_MASK[(l-1)*NI +: NI] & st & en)) q = 1'b1;
        m_taken = 1'b0; m_bad = 1'b0; irq_chg = 1'b0; tag = "R2";
        if (xr) begin
            if (exp_sync_vec(xc) != 0) begin
                m_fetch = exp_sync_vec(xc); m_taken = 1'b1; tag = "R6";
            end else begin
                m_bad = 1'b1; tag = "R7";
            end
            if (q) tag = "R8";
        end else if (q) begin
            m_taken = 1'b1; irq_chg = 1'b1;
            if (lvl > 4'd1) begin
                m_epc[int'(lvl)] = pc; m_eps[int'(lvl)] = m_ps;
                m_ps = {m_ps[7:5], 1'b1, lvl};
                m_fetch = exp_lvl_vec(lvl); tag = "R3";
            end else begin
                m_cause = 6'd4;
                if (m_ps[4]) begin
                    m_depc = pc; m_fetch = 32'h5FFF_865C; tag = "R5";
                end else begin
                    m_epc[1] = pc; m_fetch = m_ps[5] ? 32'h5FFF_863C : 32'h5FFF_861C; tag = "R4";
                end
                m_ps[4] = 1'b1;
            end
        end
        if (pw && !irq_chg) m_ps = pd;
        if (pw && tag == "R2") tag = "R10";
        if (lw) m_lbase = ld;
        @(posedge clk);
        #(CLK_PERIOD/4);
        compare_all(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; exc_req = 1'b0; ps_wr_en = 1'b0; lbase_wr_en = 1'b0;
        irq_level = '0;
        repeat (2) @(posedge clk);
        #(CLK_PERIOD/4);
        m_fetch = 32'h5FFF_8000; m_ps = 8'h1F; m_cause = '0; m_depc = '0;
        m_taken = 1'b0; m_bad = 1'b0;
        for (int l = 1; l <= NL; l++) m_epc[l] = '0;
        for (int l = 2; l <= NL; l++) m_eps[l] = '0;
        m_lbase = {lbase[31:1], 1'b0};
        check("R1", "reset fetch_pc", fetch_pc, 32'h5FFF_8000);
        check("R1", "reset ps", 32'(ps), 32'h1F);
        check("R1", "reset lbase bit0", 32'(lbase[0]), 32'h0);
        check("R1", "reset taken", 32'(taken), 32'h0);
        check("R1", "reset bad_exc", 32'(bad_exc), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    localparam logic [NI-1:0] ALL = '1;

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R1: upper literal-base bits survive reset, bit 0 cleared
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h0000_1235);
        do_reset();
        check("R1", "lbase after reset", lbase, 32'h0000_1234);
        // level 4 timer line with intlevel 0
        step(0, 0, 0, 0, 0, 0, 1, 8'h00, 0, 0);
        step(4, 13'h1, 13'h1, 0, 0, 32'h100, 0, 0, 0, 0);
        check("R3", "level4 vector", fetch_pc, 32'h5FFF_85BC);
        // level equal to intlevel, then level 7: not taken
        step(4, ALL, ALL, 0, 0, 32'h104, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 1, 8'h00, 0, 0);
        step(7, ALL, ALL, 0, 0, 32'h108, 0, 0, 0, 0);
        // enabled but not pending: not taken
        step(3, 13'h0, ALL, 0, 0, 32'h10C, 0, 0, 0, 0);
        // level 1 in user mode, kernel mode, then double
        step(0, 0, 0, 0, 0, 0, 1, 8'h20, 0, 0);
        step(1, 13'h2, 13'h2, 0, 0, 32'h200, 0, 0, 0, 0);
        check("R4", "user vector", fetch_pc, 32'h5FFF_863C);
        step(1, 13'h2, 13'h2, 0, 0, 32'h204, 0, 0, 0, 0);
        check("R5", "double vector", fetch_pc, 32'h5FFF_865C);
        step(0, 0, 0, 0, 0, 0, 1, 8'h00, 0, 0);
        step(1, 13'h4, 13'h4, 0, 0, 32'h208, 0, 0, 0, 0);
        check("R4", "kernel vector", fetch_pc, 32'h5FFF_861C);
        // all sync codes including empty ones
        for (int c = 0; c < 16; c++) step(0, 0, 0, 1, 4'(c), 32'h300, 0, 0, 0, 0);
        // request and interrupt together; status write and entry together
        step(0, 0, 0, 0, 0, 0, 1, 8'h00, 0, 0);
        step(6, ALL, ALL, 1, 4'd5, 32'h400, 0, 0, 0, 0);
        step(6, ALL, ALL, 1, 4'd12, 32'h404, 0, 0, 0, 0);
        step(5, ALL, ALL, 0, 0, 32'h408, 1, 8'hC0, 0, 0);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] lv = ($urandom % 16 == 0) ? 4'hF : 4'($urandom % 8);
            logic [7:0] pd = 8'($urandom);
            pd[3:0] = 4'($urandom % 3);
            step(lv, NI'($urandom), NI'($urandom), ($urandom % 5) == 0, 4'($urandom),
                 $urandom, ($urandom % 6) == 0, pd, ($urandom % 20) == 0, $urandom);
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD*200000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule